// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block turns one vector instruction into a stream of element operations. The instruction carries a vector length, a saved source step and a saved destination step, and a predicate for each side. A source cursor and a destination cursor each skip element positions whose predicate bit is clear. Each emitted operation pairs the next enabled source element with the next enabled destination element. Because the two masks act independently, one instruction can compress a sparse source into a dense destination, or expand a dense source into a sparse destination.

Predicates are decoded inside the block. A predicate can come from an integer register, from its bitwise inverse, or from a one-hot value of 1 shifted left by a register value. It can also come from the equal bits of consecutive condition fields, in a direct or an inverted form. Scalar operand flags change how the loop runs. A scalar source repeats element 0. A scalar destination stops the loop after its first operation.

Operations leave on a valid/ready stream. The sequencer holds `iss_valid` and both indices steady until `iss_ready` is sampled high at a clock edge. Neither cursor moves while the consumer stalls, so the consumer can apply back-pressure for as long as it needs. The step outputs show the cursors, which makes an interrupted loop resumable. When the instruction finishes, a one-cycle `done` pulse is raised and both steps return to zero.

Top module: `twin_pred_sequencer`

## Requirements
- R1: A `start` sampled while idle latches VL, both steps, both decoded masks and both scalar flags. A `start` sampled while busy has no effect on the operation stream.
- R2: When `start` is taken with VL = 0, no operation is issued, `busy` stays low, and `done` is high in the cycle right after that edge.
- R3: Each operation carries the lowest enabled source position at or above the source cursor and the lowest enabled destination position at or above the destination cursor. After each accepted operation, each cursor moves to one past the position it just used. Masked or unreached destinations never appear.
- R4: The loop ends once either side has no enabled position below VL. Without a scalar destination, `done` rises two cycles after the edge that accepted the last operation, or two cycles after the start edge if nothing was issued. `done` lasts one cycle.
- R5: While `iss_valid` is high and `iss_ready` is low, valid and both indices hold, and neither cursor moves.
- R6: The predicate mode is a 3-bit code. 0 enables all elements. 1 takes bit i of the register, and 2 takes the inverse of that bit; both give 0 at i ≥ 64. 3 enables only element r, and nothing if r ≥ 128. 6 and 7 enable nothing.
- R7: Mode 4 enables element i when the equal bit of condition field 4+i is 1, and mode 5 when that bit is 0. Field f sits at `cr_bits[4f+3:4f]` with the equal bit at `4f+1`. Fields at or beyond 16 disable the element.
- R8: With the destination scalar, the destination predicate is ignored, `iss_dst` is 0, and `done` rises in the cycle after the first accepted operation.
- R9: With the source scalar, the source predicate is ignored, `iss_src` is always 0, and the source cursor still advances by one per operation.
- R10: Nonzero initial steps resume the loop from those positions, and mask bits below each starting step are ignored.
- R11: `src_step` and `dst_step` show the cursors: the initial values after start, one past the last used position after each accept, and 0 from the `done` cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| vl | input | 7 | Vector length |
| init_src_step | input | 7 | Saved source step |
| init_dst_step | input | 7 | Saved destination step |
| src_mode | input | 3 | Source predicate mode code |
| dst_mode | input | 3 | Destination predicate mode code |
| src_reg | input | 64 | Register value for the source predicate |
| dst_reg | input | 64 | Register value for the destination predicate |
| cr_bits | input | 64 | Condition fields, 4 bits each |
| src_scalar | input | 1 | Source operand is scalar |
| dst_scalar | input | 1 | Destination operand is scalar |
| iss_valid | output | 1 | Element operation offered |
| iss_ready | input | 1 | Consumer accepts the operation |
| iss_src | output | 7 | Source element index |
| iss_dst | output | 7 | Destination element index |
| src_step | output | 7 | Current source cursor |
| dst_step | output | 7 | Current destination cursor |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first operation is offered in the cycle after the start edge. Each later offer appears in the cycle after the accepting edge, since the indices are found combinationally from the registered cursors. `done` follows the last accept by two cycles, by one cycle for a scalar destination, and by one cycle after start when VL is zero. The bench drives inputs and samples outputs on the falling edge and counts falling edges from the start edge. It checks `done` against the exact cycle its reference model predicts, and checks each stalled offer one cycle later for unchanged indices.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

  typedef enum logic [2:0] {
    PM_ALL     = 3'd0,
    PM_REG     = 3'd1,
    PM_REG_INV = 3'd2,
    PM_ONEHOT  = 3'd3,
    PM_CR_EQ   = 3'd4,
    PM_CR_NE   = 3'd5
  } pred_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/pred_decode.sv
module pred_decode import seqr_pkg::*; #(
  parameter int IDX_W   = 7,
  parameter int REG_W   = 64,
  parameter int CRF_N   = 16,
  parameter int CR_BASE = 4,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic [2:0]         mode,
  input  logic [REG_W-1:0]   reg_val,
  input  logic [4*CRF_N-1:0] cr_bits,
  output logic [MASK_W-1:0]  mask
);

  logic hi_zero;
  logic unused_bits;

  // one-hot form is empty when the shift amount is out of range
  if (REG_W > IDX_W) begin : g_hi
    assign hi_zero = ~|reg_val[REG_W-1:IDX_W];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign unused_bits = ^{cr_bits, reg_val};

  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    logic r_bit, r_inv, eq_bit, ne_bit, h_bit;

    if (i < REG_W) begin : g_r
      assign r_bit = reg_val[i];
      assign r_inv = ~reg_val[i];
    end else begin : g_nr
      assign r_bit = 1'b0;
      assign r_inv = 1'b0;
    end

    if (CR_BASE + i < CRF_N) begin : g_c
      assign eq_bit = cr_bits[4*(CR_BASE+i)+1];
      assign ne_bit = ~cr_bits[4*(CR_BASE+i)+1];
    end else begin : g_nc
      assign eq_bit = 1'b0;
      assign ne_bit = 1'b0;
    end

    assign h_bit = hi_zero && (reg_val[IDX_W-1:0] == IDX_W'(i));

    assign mask[i] = (mode == PM_ALL)     ? 1'b1   :
                     (mode == PM_REG)     ? r_bit  :
                     (mode == PM_REG_INV) ? r_inv  :
                     (mode == PM_ONEHOT)  ? h_bit  :
                     (mode == PM_CR_EQ)   ? eq_bit :
                     (mode == PM_CR_NE)   ? ne_bit : 1'b0;
  end

endmodule

// File: rtl/step_scan.sv
module step_scan #(
  parameter int IDX_W = 7,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [IDX_W-1:0]  step,
  input  logic [IDX_W-1:0]  vl,
  output logic              hit,
  output logic [IDX_W-1:0]  pos
);

  logic any_set;

  // lowest enabled position at or above the cursor
  always_comb begin
    any_set = 1'b0;
    pos     = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(step))) begin
        any_set = 1'b1;
        pos     = IDX_W'(i);
      end
    end
  end

  assign hit = any_set && (pos < vl);

endmodule

// File: rtl/twin_pred_sequencer.sv
module twin_pred_sequencer import seqr_pkg::*; #(
  parameter int IDX_W   = 7,
  parameter int REG_W   = 64,
  parameter int CRF_N   = 16,
  parameter int CR_BASE = 4,
  localparam int MASK_W = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   vl,
  input  logic [IDX_W-1:0]   init_src_step,
  input  logic [IDX_W-1:0]   init_dst_step,
  input  logic [2:0]         src_mode,
  input  logic [2:0]         dst_mode,
  input  logic [REG_W-1:0]   src_reg,
  input  logic [REG_W-1:0]   dst_reg,
  input  logic [4*CRF_N-1:0] cr_bits,
  input  logic               src_scalar,
  input  logic               dst_scalar,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [IDX_W-1:0]   iss_src,
  output logic [IDX_W-1:0]   iss_dst,
  output logic [IDX_W-1:0]   src_step,
  output logic [IDX_W-1:0]   dst_step,
  output logic               busy,
  output logic               done
);

  seq_state_e         state_q;
  logic [IDX_W-1:0]   vl_q, sstep_q, dstep_q;
  logic [MASK_W-1:0]  smask_in, dmask_in, smask_q, dmask_q;
  logic               sscal_q, dscal_q, done_q;
  logic               s_hit, d_hit;
  logic [IDX_W-1:0]   s_pos, d_pos;
  logic               pair_ok, accept;

  pred_decode #(.IDX_W(IDX_W), .REG_W(REG_W), .CRF_N(CRF_N), .CR_BASE(CR_BASE)) u_sdec (
    .mode(src_mode), .reg_val(src_reg), .cr_bits(cr_bits), .mask(smask_in)
  );

  pred_decode #(.IDX_W(IDX_W), .REG_W(REG_W), .CRF_N(CRF_N), .CR_BASE(CR_BASE)) u_ddec (
    .mode(dst_mode), .reg_val(dst_reg), .cr_bits(cr_bits), .mask(dmask_in)
  );

  step_scan #(.IDX_W(IDX_W)) u_sscan (
    .mask(smask_q), .step(sstep_q), .vl(vl_q), .hit(s_hit), .pos(s_pos)
  );

  step_scan #(.IDX_W(IDX_W)) u_dscan (
    .mask(dmask_q), .step(dstep_q), .vl(vl_q), .hit(d_hit), .pos(d_pos)
  );

  assign pair_ok   = (state_q == ST_RUN) && s_hit && d_hit;
  assign accept    = pair_ok && iss_ready;
  assign iss_valid = pair_ok;
  assign iss_src   = sscal_q ? '0 : s_pos;
  assign iss_dst   = dscal_q ? '0 : d_pos;
  assign src_step  = sstep_q;
  assign dst_step  = dstep_q;
  assign busy      = (state_q == ST_RUN);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      smask_q <= '0;
      dmask_q <= '0;
      sscal_q <= 1'b0;
      dscal_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (vl == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              vl_q    <= vl;
              sstep_q <= init_src_step;
              dstep_q <= init_dst_step;
              smask_q <= src_scalar ? '1 : smask_in;
              dmask_q <= dst_scalar ? '1 : dmask_in;
              sscal_q <= src_scalar;
              dscal_q <= dst_scalar;
            end
          end
        end
        default: begin
          if (!pair_ok) begin
            state_q <= ST_IDLE;
            sstep_q <= '0;
            dstep_q <= '0;
            done_q  <= 1'b1;
          end else if (accept) begin
            if (dscal_q) begin
              state_q <= ST_IDLE;
              sstep_q <= '0;
              dstep_q <= '0;
              done_q  <= 1'b1;
            end else begin
              sstep_q <= s_pos + 1'b1;
              dstep_q <= d_pos + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R5: stalled offer holds
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_src) && $stable(iss_dst));

  // R5: cursors frozen while stalled
  p_no_step_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ok && !iss_ready |=> $stable(sstep_q) && $stable(dstep_q));

  // R3: issued positions are enabled and not below the cursors
  p_issue_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> smask_q[s_pos] && dmask_q[d_pos] && (s_pos >= sstep_q) && (d_pos >= dstep_q));

  // R4: nothing issued at or beyond VL
  p_issue_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (s_pos < vl_q) && (d_pos < vl_q));

  // R11: steps cleared when done
  p_steps_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && (src_step == '0) && (dst_step == '0));

  // R2: zero length completes at once
  p_vl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (vl == '0) |=> done && !busy);

  // R8: scalar destination stops after one op
  p_scalar_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && dscal_q |=> done);

  // R1: latched length does not change while busy
  p_busy_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vl_q));

endmodule

// File: tb/twin_pred_sequencer_test.sv
module twin_pred_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0, init_src_step = '0, init_dst_step = '0;
  logic [2:0]  src_mode = '0, dst_mode = '0;
  logic [63:0] src_reg = '0, dst_reg = '0, cr_bits = '0;
  logic        src_scalar = 1'b0, dst_scalar = 1'b0;
  logic        iss_ready = 1'b0;
  logic        iss_valid, busy, done;
  logic [6:0]  iss_src, iss_dst, src_step, dst_step;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  twin_pred_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .init_src_step(init_src_step), .init_dst_step(init_dst_step),
    .src_mode(src_mode), .dst_mode(dst_mode), .src_reg(src_reg), .dst_reg(dst_reg),
    .cr_bits(cr_bits), .src_scalar(src_scalar), .dst_scalar(dst_scalar),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_src(iss_src), .iss_dst(iss_dst),
    .src_step(src_step), .dst_step(dst_step), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic bit pbit(input logic [2:0] m, input logic [63:0] r,
                              input logic [63:0] cr, input int i);
    case (m)
      3'd0: return 1'b1;
      3'd1: return (i < 64) ? r[i] : 1'b0;
      3'd2: return (i < 64) ? ~r[i] : 1'b0;
      3'd3: return (r < 64'd128) && (r == 64'(i));
      3'd4: return (i + 4 < 16) ? cr[4*(i+4)+1] : 1'b0;
      3'd5: return (i + 4 < 16) ? ~cr[4*(i+4)+1] : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_case(input string req, input int n_vl, input int ss, input int ds,
                          input logic [2:0] sm, input logic [2:0] dm,
                          input logic [63:0] sr, input logic [63:0] dr, input logic [63:0] cr,
                          input bit sscal, input bit dscal, input bit mid_start);
    int es[128];
    int ed[128];
    int n = 0;
    int s = ss;
    int d = ds;
    int k = 0;
    int last = -1;
    int done_t = -1;
    bit hold = 0;
    int hs = 0;
    int hd = 0;
    int exp_done;
    // reference sequence from the requirements
    forever begin
      int sp = -1;
      int dp = -1;
      for (int i = s; i < n_vl; i++) if (sp < 0 && (sscal || pbit(sm, sr, cr, i))) sp = i;
      for (int i = d; i < n_vl; i++) if (dp < 0 && (dscal || pbit(dm, dr, cr, i))) dp = i;
      if (sp < 0 || dp < 0) break;
      es[n] = sscal ? 0 : sp;
      ed[n] = dscal ? 0 : dp;
      n++;
      s = sp + 1;
      d = dp + 1;
      if (dscal) break;
    end

    @(negedge clk);
    vl = 7'(n_vl); init_src_step = 7'(ss); init_dst_step = 7'(ds);
    src_mode = sm; dst_mode = dm; src_reg = sr; dst_reg = dr; cr_bits = cr;
    src_scalar = sscal; dst_scalar = dscal; start = 1'b1; iss_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (n_vl == 0) begin
      chk(done === 1'b1, "R2", "done after zero-length start", int'(done), 1);
      chk(!iss_valid && !busy, "R2", "no issue at zero length", int'(iss_valid), 0);
      @(negedge clk);
      chk(done === 1'b0, "R4", "done lasts one cycle", int'(done), 0);
      return;
    end
    chk(src_step == 7'(ss) && dst_step == 7'(ds), "R11", "steps loaded at start",
        int'(src_step), ss);
    for (int t = 0; t < 1000; t++) begin
      if (mid_start && t == 2) begin
        start = 1'b1; vl = '0;
      end else begin
        start = 1'b0;
      end
      iss_ready = ($urandom % 10) < 6;
      if (hold) begin
        chk(iss_valid && iss_src == 7'(hs) && iss_dst == 7'(hd), "R5",
            "stalled offer held", int'(iss_src), hs);
      end
      hold = 1'b0;
      if (done) begin
        done_t = t;
        break;
      end
      if (iss_valid) begin
        if (k < n) begin
          chk(iss_src == 7'(es[k]), req, "source index", int'(iss_src), es[k]);
          chk(iss_dst == 7'(ed[k]), req, "destination index", int'(iss_dst), ed[k]);
        end else begin
          chk(1'b0, "R4", "operation beyond end", k, n);
        end
        if (iss_ready) begin
          k++;
          last = t;
        end else begin
          hold = 1'b1; hs = int'(iss_src); hd = int'(iss_dst);
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    iss_ready = 1'b0;
    exp_done = (n == 0) ? 1 : (dscal ? last + 1 : last + 2);
    chk(k == n, "R4", "operation count", k, n);
    chk(done_t == exp_done, dscal ? "R8" : "R4", "done cycle", done_t, exp_done);
    chk(src_step == 0 && dst_step == 0 && !busy, "R11", "steps cleared at done",
        int'(src_step) + int'(dst_step), 0);
    @(negedge clk);
    chk(done === 1'b0, "R4", "done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !iss_valid && src_step == 0 && dst_step == 0, "R1",
        "reset state", int'(busy) + int'(done) + int'(iss_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // plain vector, all enabled
    run_case("R3", 2, 0, 0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 0);
    // zero length
    run_case("R2", 0, 0, 0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 0);
    // scalar destination ends after one op
    run_case("R8", 2, 0, 0, 3'd0, 3'd0, 0, 0, 0, 0, 1, 0);
    // scalar source repeats element 0
    run_case("R9", 2, 0, 0, 3'd1, 3'd0, 64'b11, 0, 0, 1, 0, 0);
    // inverted source vs direct destination: one op 0->1
    run_case("R6", 2, 0, 0, 3'd2, 3'd1, 64'b10, 64'b10, 0, 0, 0, 0);
    // compress
    run_case("R3", 3, 0, 0, 3'd1, 3'd0, 64'b101, 0, 0, 0, 0, 0);
    // expand
    run_case("R3", 3, 0, 0, 3'd0, 3'd1, 0, 64'b101, 0, 0, 0, 0);
    // resume from saved steps
    run_case("R10", 4, 1, 2, 3'd1, 3'd2, 64'b0101, 64'b0101, 0, 0, 0, 0);
    // one-hot destination, register source
    run_case("R6", 3, 0, 0, 3'd1, 3'd3, 64'b100, 64'd1, 0, 0, 0, 0);
    // one-hot out of range enables nothing
    run_case("R6", 5, 0, 0, 3'd3, 3'd0, 64'd200, 0, 0, 0, 0, 0);
    // condition fields, inverted: field 4 eq=1, field 5 eq=0
    run_case("R7", 2, 0, 0, 3'd5, 3'd5, 0, 0, 64'h0002_0000, 0, 0, 0);
    run_case("R7", 14, 0, 0, 3'd4, 3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    // all-zero mask, then its inverse
    run_case("R6", 3, 0, 0, 3'd1, 3'd0, 0, 0, 0, 0, 0, 0);
    run_case("R6", 3, 0, 0, 3'd2, 3'd2, 0, 0, 0, 0, 0, 0);
    // undefined mode code
    run_case("R6", 4, 0, 0, 3'd6, 3'd0, 0, 0, 0, 0, 0, 0);
    // start while busy ignored
    run_case("R1", 6, 0, 0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 1);
    // full length
    run_case("R3", 127, 0, 0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 0);

    for (int c = 0; c < 40; c++) begin
      int rvl = (($urandom % 4) == 0) ? int'($urandom % 128) : int'($urandom % 9);
      run_case("R3", rvl, int'($urandom % 4), int'($urandom % 4),
               3'($urandom % 8), 3'($urandom % 8),
               {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule